// File: doc/BRIEF.md
# Mixed-Class Register Bank with Hidden Stack Pointers

This block is the register storage of a small 16-bit processor core. It holds eight architectural registers of three fixed kinds. Registers 0 to 3 are 16-bit signed integers, registers 4 and 5 are 16-bit unsigned integers, and registers 6 and 7 are 32-bit containers for single-precision float bit patterns. Two combinational read ports present any register on a common 32-bit bus. Each narrow value is widened according to its kind, and each port reports a 2-bit class tag so that downstream logic knows how to interpret the word. One synchronous write port stores a 32-bit write word, trimmed to the width of the target register.

Two further registers, a stack pointer and a base pointer, sit beside the bank. The read and write ports cannot reach them. Their only source is a command input: one code copies register 4 into the stack pointer, and another code copies it into the base pointer. Both pointers leave the block as plain outputs for address generation. The block does no arithmetic, no flag work and no decoding beyond those two codes.

Top module: `mixed_regfile`

## Requirements
- R1: Eight registers are addressed by a 3-bit index. Each of the two read ports shows the selected register's current stored value combinationally, in the same cycle that the index is applied.
- R2: Registers 0 to 3 keep only bits [15:0] of the write word. A read returns that value sign-extended to 32 bits, with class tag 2'b00.
- R3: Registers 4 and 5 keep only bits [15:0] of the write word. A read returns that value zero-extended to 32 bits, with class tag 2'b01.
- R4: Registers 6 and 7 keep all 32 bits of the write word unchanged. A read returns those bits with class tag 2'b10.
- R5: A register takes new data on a rising clock edge only when `wr_en` is high and `wr_idx` selects it. Every other register keeps its value.
- R6: When `cmd_valid` is high and `cmd_code` equals 60, the stack pointer loads bits [15:0] of register 4 at the next rising edge.
- R7: When `cmd_valid` is high and `cmd_code` equals 61, the base pointer loads bits [15:0] of register 4 at the next rising edge.
- R8: If a write to register 4 and a pointer load happen on the same edge, the pointer takes the value register 4 held before that edge.
- R9: The stack pointer and base pointer keep their values when `cmd_valid` is low or `cmd_code` is any other value. General writes never change them, and the read ports never show them.
- R10: While `rst_n` is low at a rising edge, all eight registers, the stack pointer and the base pointer clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the general write port |
| wr_idx | input | 3 | Register selected for writing |
| wr_data | input | 32 | Write word, trimmed per register class |
| rd_a_idx | input | 3 | Register selected on read port A |
| rd_a_data | output | 32 | Extended value read on port A |
| rd_a_class | output | 2 | Class tag of port A: 00 signed, 01 unsigned, 10 float |
| rd_b_idx | input | 3 | Register selected on read port B |
| rd_b_data | output | 32 | Extended value read on port B |
| rd_b_class | output | 2 | Class tag of port B |
| cmd_valid | input | 1 | Qualifies `cmd_code` |
| cmd_code | input | 8 | Command: 60 loads stack pointer, 61 loads base pointer |
| sp_out | output | 16 | Current stack pointer |
| bp_out | output | 16 | Current base pointer |

## Verification
A register holding a wrong value shows up on a read port in the same cycle that its index is selected. The bench drives both read indices across all eight registers every cycle, so a corrupted register appears within one cycle of the next visit to it. If upper bits are trimmed or extended wrongly, the bits above 15 of the read word disagree with bit 15 or with zero. A pointer that is loaded at the wrong time, or from the wrong value, differs on `sp_out` or `bp_out` one edge after the command. Because the reference model samples register 4 before the edge, the same-edge conflict case shows a mismatch at once.

// File: rtl/mrf_pkg.sv
// Package: shared constants, class encoding and index-to-class mapping for
// the mixed-class register bank. Assumes the class of a register depends
// only on its index.
package mrf_pkg;

    localparam int NUM_REGS   = 8;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int BUS_W      = 32;
    localparam int NARROW_W   = 16;
    localparam int CMD_W      = 8;
    localparam int FIRST_UNS  = 4;   // first unsigned register
    localparam int FIRST_FLT  = 6;   // first float register
    localparam int PTR_SRC    = 4;   // register copied into SP/BP

    localparam logic [CMD_W-1:0] CMD_LOAD_SP = CMD_W'(60);
    localparam logic [CMD_W-1:0] CMD_LOAD_BP = CMD_W'(61);

    typedef enum logic [1:0] {
        CLS_SIGNED   = 2'b00,
        CLS_UNSIGNED = 2'b01,
        CLS_FLOAT    = 2'b10
    } reg_class_e;

    // Map a register index to its fixed class.
    function automatic reg_class_e class_of(input int idx);
        if (idx < FIRST_UNS)      return CLS_SIGNED;
        else if (idx < FIRST_FLT) return CLS_UNSIGNED;
        else                      return CLS_FLOAT;
    endfunction

endpackage

// File: rtl/mrf_slot.sv
// Module: one storage register of the bank.
// Stores STORE_W bits taken from the low end of the write word and presents
// them widened to BUS_W bits, by sign or zero extension.
// Assumes STORE_W <= BUS_W. Reset is synchronous and active low.
module mrf_slot #(
    parameter int BUS_W    = 32,
    parameter int STORE_W  = 16,
    parameter bit SIGN_EXT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BUS_W-1:0] d,
    output logic [BUS_W-1:0] q_ext
);

    localparam int PAD_W = (BUS_W > STORE_W) ? BUS_W - STORE_W : 1;

    logic [STORE_W-1:0] q;

    // Capture the trimmed write word, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d[STORE_W-1:0];
    end

    generate
        if (STORE_W >= BUS_W) begin : g_full
            // Full-width register: bits pass through unchanged.
            always_comb q_ext = q;
        end else if (SIGN_EXT) begin : g_sext
            // Signed register: replicate the top stored bit.
            always_comb q_ext = {{PAD_W{q[STORE_W-1]}}, q};
        end else begin : g_zext
            // Unsigned register: pad with zeros.
            always_comb q_ext = {{PAD_W{1'b0}}, q};
        end
    endgenerate

    // Written data shows up after the edge.
    assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(d[STORE_W-1:0]));

    // Without a write strobe the register holds.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // Reset clears the stored value.
    assert_clear_R10: assert property (@(posedge clk)
        !rst_n |=> q == '0);

endmodule

// File: rtl/mrf_rdport.sv
// Module: one combinational read port.
// Selects one extended register word by index and reports the class of
// that index. Assumes the bank array is already extended to BUS_W bits.
module mrf_rdport
    import mrf_pkg::*;
#(
    parameter int N     = 8,
    parameter int BUS_W = 32,
    parameter int IW    = $clog2(N)
) (
    input  logic [BUS_W-1:0] bank [N],
    input  logic [IW-1:0]    idx,
    output logic [BUS_W-1:0] data,
    output logic [1:0]       cls
);

    // Route the selected word and derive its class tag.
    always_comb begin
        data = bank[idx];
        cls  = class_of(int'(idx));
    end

endmodule

// File: rtl/mrf_stackptr.sv
// Module: hidden stack pointer and base pointer.
// Each one is loaded only by its own command code, from the source register
// value presented before the edge. All other cycles hold both pointers.
// Reset is synchronous and active low.
module mrf_stackptr
    import mrf_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CW-1:0]    cmd_code,
    input  logic [PTR_W-1:0] src,
    output logic [PTR_W-1:0] sp,
    output logic [PTR_W-1:0] bp
);

    logic load_sp;
    logic load_bp;

    // Decode the two pointer-load commands.
    always_comb begin
        load_sp = cmd_valid && (cmd_code == CW'(CMD_LOAD_SP));
        load_bp = cmd_valid && (cmd_code == CW'(CMD_LOAD_BP));
    end

    // Stack pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp <= '0;
        else if (load_sp) sp <= src;
    end

    // Base pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       bp <= '0;
        else if (load_bp) bp <= src;
    end

    assert_sp_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CW'(60)) |=> sp == $past(src));

    assert_bp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CW'(61)) |=> bp == $past(src));

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || (cmd_code != CW'(60) && cmd_code != CW'(61)))
        |=> ($stable(sp) && $stable(bp)));

    assert_ptr_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (sp == '0 && bp == '0));

endmodule

// File: rtl/mixed_regfile.sv
// Module: top of the mixed-class register bank.
// Eight registers whose class is fixed by index, two combinational read
// ports, one synchronous write port, and hidden stack and base pointers
// that are loaded from register PTR_SRC by command. Reset is synchronous
// and active low.
module mixed_regfile
    import mrf_pkg::*;
#(
    parameter int N_REGS   = mrf_pkg::NUM_REGS,
    parameter int DATA_W   = mrf_pkg::BUS_W,
    parameter int SHORT_W  = mrf_pkg::NARROW_W,
    parameter int CODE_W   = mrf_pkg::CMD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(N_REGS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(N_REGS)-1:0] rd_a_idx,
    output logic [DATA_W-1:0]         rd_a_data,
    output logic [1:0]                rd_a_class,
    input  logic [$clog2(N_REGS)-1:0] rd_b_idx,
    output logic [DATA_W-1:0]         rd_b_data,
    output logic [1:0]                rd_b_class,
    input  logic                      cmd_valid,
    input  logic [CODE_W-1:0]         cmd_code,
    output logic [SHORT_W-1:0]        sp_out,
    output logic [SHORT_W-1:0]        bp_out
);

    localparam int IW = $clog2(N_REGS);

    logic [DATA_W-1:0] bank_ext [N_REGS];
    logic [N_REGS-1:0] slot_we;

    // One-hot write strobe for the addressed register.
    always_comb begin
        slot_we = '0;
        if (wr_en) slot_we[wr_idx] = 1'b1;
    end

    // Build one storage slot per register, sized and extended by class.
    generate
        for (genvar i = 0; i < N_REGS; i++) begin : g_slot
            localparam bit IS_FLT = (class_of(i) == CLS_FLOAT);
            localparam bit IS_SGN = (class_of(i) == CLS_SIGNED);
            mrf_slot #(
                .BUS_W   (DATA_W),
                .STORE_W (IS_FLT ? DATA_W : SHORT_W),
                .SIGN_EXT(IS_SGN)
            ) u_slot (
                .clk  (clk),
                .rst_n(rst_n),
                .we   (slot_we[i]),
                .d    (wr_data),
                .q_ext(bank_ext[i])
            );
        end
    endgenerate

    mrf_rdport #(.N(N_REGS), .BUS_W(DATA_W), .IW(IW)) u_rd_a (
        .bank(bank_ext),
        .idx (rd_a_idx),
        .data(rd_a_data),
        .cls (rd_a_class)
    );

    mrf_rdport #(.N(N_REGS), .BUS_W(DATA_W), .IW(IW)) u_rd_b (
        .bank(bank_ext),
        .idx (rd_b_idx),
        .data(rd_b_data),
        .cls (rd_b_class)
    );

    mrf_stackptr #(.PTR_W(SHORT_W), .CW(CODE_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .src      (bank_ext[PTR_SRC][SHORT_W-1:0]),
        .sp       (sp_out),
        .bp       (bp_out)
    );

    // A signed tag must come with a sign-extended word.
    assert_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_class == 2'b00 |->
        rd_a_data[DATA_W-1:SHORT_W] == {(DATA_W-SHORT_W){rd_a_data[SHORT_W-1]}});

    // An unsigned tag must come with zero upper bits.
    assert_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_class == 2'b01 |-> rd_b_data[DATA_W-1:SHORT_W] == '0);

    // Class tags never take the unused code.
    assert_class_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_class != 2'b11 && rd_b_class != 2'b11);

    // A full-width write to a float register is read back whole.
    assert_float_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IW'(6) && rd_a_idx == wr_idx) |=>
        (rd_a_idx != $past(rd_a_idx) || rd_a_data == $past(wr_data)));

endmodule

// File: tb/mixed_regfile_bench.sv
`timescale 1ns/1ps
module mixed_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_a_idx = '0;
    logic [2:0]  rd_b_idx = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic [1:0]  rd_a_class, rd_b_class;
    logic [15:0] sp_out, bp_out;

    always #2.5 clk = ~clk;   // 200 MHz

    mixed_regfile u_mixed_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_a_class(rd_a_class), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_b_class(rd_b_class), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sp_out(sp_out), .bp_out(bp_out)
    );

    // Reference model state
    logic [31:0] m_reg [8];
    logic [15:0] m_sp, m_bp;
    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Expected read word for a register, from the class rules.
    function automatic logic [31:0] exp_word(input int i);
        if (i < 4)      return {{16{m_reg[i][15]}}, m_reg[i][15:0]};
        else if (i < 6) return {16'h0, m_reg[i][15:0]};
        else            return m_reg[i];
    endfunction

    function automatic logic [1:0] exp_cls(input int i);
        if (i < 4)      return 2'b00;
        else if (i < 6) return 2'b01;
        else            return 2'b10;
    endfunction

    function automatic string cls_tag(input int i);
        if (i < 4)      return "R2";
        else if (i < 6) return "R3";
        else            return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output with the model for the inputs now applied.
    task automatic compare_all(input string tag);
        check({tag, " R1 ", cls_tag(int'(rd_a_idx)), " rd_a_data"},
              rd_a_data, exp_word(int'(rd_a_idx)));
        check({tag, " R1 ", cls_tag(int'(rd_b_idx)), " rd_b_data"},
              rd_b_data, exp_word(int'(rd_b_idx)));
        check({tag, " ", cls_tag(int'(rd_a_idx)), " rd_a_class"},
              32'(rd_a_class), 32'(exp_cls(int'(rd_a_idx))));
        check({tag, " ", cls_tag(int'(rd_b_idx)), " rd_b_class"},
              32'(rd_b_class), 32'(exp_cls(int'(rd_b_idx))));
        check({tag, " R6 sp_out"}, 32'(sp_out), 32'(m_sp));
        check({tag, " R7 bp_out"}, 32'(bp_out), 32'(m_bp));
    endtask

    // Apply one cycle of stimulus, check outputs, then advance the model.
    task automatic step(input string tag, input logic rn, input logic we,
                        input logic [2:0] wi, input logic [31:0] wd,
                        input logic [2:0] ra, input logic [2:0] rb,
                        input logic cv, input logic [7:0] cc);
        logic [15:0] old4;
        @(negedge clk);
        rst_n = rn; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_a_idx = ra; rd_b_idx = rb; cmd_valid = cv; cmd_code = cc;
        #1;
        compare_all(tag);
        @(posedge clk);
        old4 = m_reg[4][15:0];
        if (!rn) begin
            for (int i = 0; i < 8; i++) m_reg[i] = '0;
            m_sp = '0; m_bp = '0;
        end else begin
            if (we) m_reg[wi] = (wi >= 6) ? wd : {16'h0, wd[15:0]};
            if (cv && cc == 8'd60) m_sp = old4;
            if (cv && cc == 8'd61) m_bp = old4;
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_sp = '0; m_bp = '0;
        // First reset edge: model starts cleared (R10).
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 3, 32'hFFFF_FFFF, 3, 4, 1, 8'd60);
        for (int i = 0; i < 8; i++) step("R10", 1, 0, 0, 0, 3'(i), 3'(7-i), 0, 0);
        // Negative and positive values in signed regs (R2).
        step("R2", 1, 1, 0, 32'h1234_8001, 0, 0, 0, 0);
        step("R2", 1, 1, 3, 32'hABCD_7FFF, 0, 3, 0, 0);
        // Unsigned with top bit set (R3).
        step("R3", 1, 1, 4, 32'h5555_F00D, 3, 4, 0, 0);
        step("R3", 1, 1, 5, 32'h0000_8000, 4, 5, 0, 0);
        // Float full width (R4).
        step("R4", 1, 1, 6, 32'hC049_0FDB, 5, 6, 0, 0);
        step("R4", 1, 1, 7, 32'h8000_0001, 6, 7, 0, 0);
        step("R4", 1, 0, 7, 32'hFFFF_FFFF, 7, 0, 0, 0);
        // wr_en low: no change (R5).
        step("R5", 1, 0, 0, 32'h0000_7777, 0, 6, 0, 0);
        step("R5", 1, 0, 2, 32'h0, 0, 2, 0, 0);
        // Load SP then BP from reg 4 (R6, R7).
        step("R6", 1, 0, 0, 0, 4, 4, 1, 8'd60);
        step("R6", 1, 0, 0, 0, 4, 4, 0, 8'd60);
        step("R7", 1, 1, 4, 32'h0000_2222, 4, 0, 1, 8'd61);
        step("R7", 1, 0, 0, 0, 4, 0, 0, 0);
        // Same-edge write to reg 4 and SP load: old value (R8).
        step("R8", 1, 1, 4, 32'h0000_9999, 4, 4, 1, 8'd60);
        step("R8", 1, 1, 4, 32'h0000_4444, 4, 4, 1, 8'd61);
        step("R8", 1, 0, 0, 0, 4, 4, 0, 0);
        // Other codes, valid low, general writes: pointers hold (R9).
        step("R9", 1, 1, 4, 32'h0000_1111, 4, 4, 1, 8'd59);
        step("R9", 1, 1, 4, 32'h0000_3333, 4, 4, 1, 8'd62);
        step("R9", 1, 1, 4, 32'h0000_5A5A, 4, 4, 0, 8'd60);
        step("R9", 1, 0, 0, 0, 4, 4, 0, 8'd61);
        // Random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] cc;
            int pick;
            pick = $urandom_range(0, 3);
            cc = (pick == 0) ? 8'd60 : (pick == 1) ? 8'd61 : 8'($urandom);
            step("R1", ($urandom_range(0, 199) != 0), 1'($urandom),
                 3'($urandom), $urandom, 3'($urandom), 3'($urandom),
                 1'($urandom), cc);
        end
        // Reset mid-run clears everything (R10).
        step("R10", 0, 1, 6, 32'hDEAD_BEEF, 6, 4, 1, 8'd60);
        step("R10", 1, 0, 0, 0, 6, 4, 0, 0);
        step("R10", 1, 0, 0, 0, 0, 7, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(5 * 50000);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL R1: watchdog expired, actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule